// File: doc/BRIEF.md
# UART Sleep and RX Wake Controller

This block decides when an idle UART may drop into a low-power sleep state and when it has to leave it again. It watches the receive line, a set of idle indications, and a sleep-enable bit. The idle indications are the two FIFOs being empty, both shift registers being idle, and no interrupt waiting. Its sleep flag gates the UART's internal clock enable. A one-cycle wake pulse tells the rest of the UART that it has just woken.

The receive line is asynchronous, so it passes through a synchroniser before any decision uses it. One bit of an 8-bit advanced control byte selects how the line is treated:
- **Level mode:** a low line both prevents sleep and wakes a sleeping UART.
- **Edge mode:** the line value at sleep entry is remembered, and any change from it wakes the UART. Sleep may be entered while the line is low.

The control is a three-state machine:
- **ST_AWAKE:** normal operation.
  - Transition *enter*: ST_AWAKE to ST_SLEEP when entry is qualified.
  - Otherwise *stay_awake*.
- **ST_SLEEP:** the clock enable is gated.
  - Transition *wake*: ST_SLEEP to ST_WAKE on a wake condition.
  - Otherwise *stay_asleep*.
- **ST_WAKE:** lasts one cycle and carries the wake pulse.
  - Transition *resume*: ST_WAKE to ST_AWAKE, always.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After reset `sleep_o` and `wake_pulse_o` are both 0.
- R2: `rx_pin` passes through two synchronising flops. A change on `rx_pin` made between clock edges produces `wake_pulse_o` after the third rising edge and not before.
- R3: Sleep is entered only when all of these hold: `sleep_en`=1, `rx_fifo_empty`=1, `tx_fifo_empty`=1, `rx_shift_idle`=1, `tx_shift_idle`=1 and `irq_pending`=0. When they hold (and the mode condition allows), `sleep_o` rises one rising edge later. If any one of them fails, the block stays awake.
- R4: In level mode (`adv_ctrl[4]`=0), sleep is never entered while the synchronised RX is 0.
- R5: In level mode, a sleeping block wakes when the synchronised RX is 0.
- R6: In edge mode (`adv_ctrl[4]`=1), sleep is entered even while RX is 0.
- R7: In edge mode, the synchronised RX value is captured at sleep entry. A rise or a fall away from that value wakes the block. An unchanged RX keeps it asleep.
- R8: A wake puts the block in ST_WAKE for exactly one cycle. In that cycle `wake_pulse_o`=1 and `sleep_o`=0. `sleep_o` is also 0 in the cycle after the wake pulse, even if entry is still qualified.
- R9: Clearing `sleep_en` while asleep causes a wake through ST_WAKE.
- R10: Only bit 4 of `adv_ctrl` has an effect. Bits 7:5 and 3:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | Asynchronous receive line, idle high |
| sleep_en | input | 1 | Sleep permitted |
| adv_ctrl | input | 8 | Advanced control byte; bit 4 = 1 selects edge mode |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| rx_shift_idle | input | 1 | Receive shift register idle |
| tx_shift_idle | input | 1 | Transmit shift register idle |
| irq_pending | input | 1 | An interrupt is waiting |
| sleep_o | output | 1 | Sleeping; gates the clock enable |
| wake_pulse_o | output | 1 | One-cycle pulse on wake |

## Verification
The bench targets these corner cases:
- **Synchroniser latency.** It counts edges after an RX change. A design with one flop too few or too many would wake a cycle early or late.
- **Low line in level mode.** It holds RX low with everything else idle. A design that ignored the line in level mode would sleep there.
- **Edge mode in both directions.** It sleeps with RX low and wakes on a rise, then sleeps with RX high and wakes on a fall. A design that compared against a fixed level instead of the captured value would miss one direction or wake at once.
- **Immediate re-entry.** It checks the cycle after the wake pulse while entry is still qualified. A design that skipped re-evaluation would show sleep there.
- **Individual idle terms and control bits.** It drops each idle term alone and drives every non-mode control bit. A bad decode would enter sleep, or change mode, where it should not.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } sw_state_t;
endpackage

// File: rtl/swc_rx_sync.sv
module swc_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/swc_idle_qual.sv
module swc_idle_qual #(
    parameter int N_IDLE = 5
) (
    input  logic [N_IDLE-1:0] idle_terms,
    input  logic              sleep_en,
    input  logic              edge_mode,
    input  logic              rx_s,
    output logic              all_idle,
    output logic              entry_ok
);
    always_comb begin
        all_idle = &idle_terms;
        entry_ok = sleep_en && all_idle && (edge_mode || rx_s);
    end
endmodule

// File: rtl/swc_wake_detect.sv
module swc_wake_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic edge_mode,
    input  logic rx_s,
    output logic rx_wake
);
    logic rx_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rx_ref <= 1'b1;
        else if (capture) rx_ref <= rx_s;
    end

    always_comb begin
        if (edge_mode) rx_wake = (rx_s != rx_ref);
        else           rx_wake = !rx_s;
    end
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import sleep_wake_pkg::*;
#(
    parameter int CTRL_W      = 8,
    parameter int MODE_BIT    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_pin,
    input  logic              sleep_en,
    input  logic [CTRL_W-1:0] adv_ctrl,
    input  logic              rx_fifo_empty,
    input  logic              tx_fifo_empty,
    input  logic              rx_shift_idle,
    input  logic              tx_shift_idle,
    input  logic              irq_pending,
    output logic              sleep_o,
    output logic              wake_pulse_o
);
    localparam int N_IDLE = 5;

    sw_state_t   state, state_nx;
    logic        rx_s;
    logic        edge_mode;
    logic        all_idle;
    logic        entry_ok;
    logic        rx_wake;
    logic        capture;
    logic [N_IDLE-1:0] idle_terms;

    assign edge_mode  = adv_ctrl[MODE_BIT];
    assign idle_terms = {rx_fifo_empty, tx_fifo_empty, rx_shift_idle,
                         tx_shift_idle, !irq_pending};

    swc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rx_pin),
        .sync_o  (rx_s)
    );

    swc_idle_qual #(.N_IDLE(N_IDLE)) u_qual (
        .idle_terms (idle_terms),
        .sleep_en   (sleep_en),
        .edge_mode  (edge_mode),
        .rx_s       (rx_s),
        .all_idle   (all_idle),
        .entry_ok   (entry_ok)
    );

    assign capture = (state == ST_AWAKE) && entry_ok;

    swc_wake_detect u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .edge_mode (edge_mode),
        .rx_s      (rx_s),
        .rx_wake   (rx_wake)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_AWAKE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AWAKE: if (entry_ok)              state_nx = ST_SLEEP;  // enter
            ST_SLEEP: if (rx_wake || !sleep_en)  state_nx = ST_WAKE;   // wake
            ST_WAKE:                             state_nx = ST_AWAKE;  // resume
            default:                             state_nx = ST_AWAKE;
        endcase
    end

    // outputs
    always_comb begin
        sleep_o      = 1'b0;
        wake_pulse_o = 1'b0;
        unique case (state)
            ST_AWAKE: ;
            ST_SLEEP: sleep_o      = 1'b1;
            ST_WAKE:  wake_pulse_o = 1'b1;
            default:  ;
        endcase
    end

    AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(sleep_en && all_idle)) else $error("entry"); // R3
    AST_LEVEL_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AWAKE && !edge_mode && !rx_s) |=> !sleep_o) else $error("level"); // R4
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |=> !wake_pulse_o) else $error("pulse"); // R8
    AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |-> $past(sleep_o)) else $error("from"); // R8
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |=> !sleep_o) else $error("reentry"); // R8
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_o && wake_pulse_o)) else $error("excl"); // R8
    AST_EN_DROP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !sleep_en) |=> wake_pulse_o) else $error("en"); // R9
endmodule

// File: tb/uart_sleep_ctrl_bench.sv
module uart_sleep_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1;
    logic       sleep_en = 1'b0;
    logic [7:0] adv_ctrl = 8'h00;
    logic       rx_fifo_empty = 1'b1, tx_fifo_empty = 1'b1;
    logic       rx_shift_idle = 1'b1, tx_shift_idle = 1'b1;
    logic       irq_pending = 1'b0;
    logic       sleep_o, wake_pulse_o;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    uart_sleep_ctrl u_uart_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .sleep_en(sleep_en),
        .adv_ctrl(adv_ctrl), .rx_fifo_empty(rx_fifo_empty),
        .tx_fifo_empty(tx_fifo_empty), .rx_shift_idle(rx_shift_idle),
        .tx_shift_idle(tx_shift_idle), .irq_pending(irq_pending),
        .sleep_o(sleep_o), .wake_pulse_o(wake_pulse_o)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic all_idle_on();
        rx_fifo_empty = 1'b1; tx_fifo_empty = 1'b1;
        rx_shift_idle = 1'b1; tx_shift_idle = 1'b1; irq_pending = 1'b0;
    endtask

    // leave sleep (if any) and settle awake with rx at given level
    task automatic settle(logic rx, logic [7:0] ctrl);
        sleep_en = 1'b0; all_idle_on(); adv_ctrl = ctrl; rx_pin = rx;
        tick(5);
    endtask

    task automatic t_reset();
        check("R1", "sleep after reset", sleep_o, 1'b0);
        check("R1", "wake after reset", wake_pulse_o, 1'b0);
    endtask

    task automatic t_level_entry_and_wake();
        settle(1'b1, 8'h00);
        sleep_en = 1'b1;
        tick(1);
        check("R3", "sleep one edge after qualified", sleep_o, 1'b1);
        rx_pin = 1'b0;
        tick(2);
        check("R2", "still asleep after two edges", sleep_o, 1'b1);
        check("R2", "no early wake", wake_pulse_o, 1'b0);
        tick(1);
        check("R5", "level low wakes", wake_pulse_o, 1'b1);
        check("R8", "sleep low during wake", sleep_o, 1'b0);
        tick(1);
        check("R8", "pulse one cycle", wake_pulse_o, 1'b0);
        tick(3);
        check("R4", "level low blocks entry", sleep_o, 1'b0);
    endtask

    task automatic t_idle_terms();
        for (int k = 0; k < 6; k++) begin
            settle(1'b1, 8'h00);
            sleep_en = 1'b1;
            case (k)
                0: sleep_en = 1'b0;
                1: rx_fifo_empty = 1'b0;
                2: tx_fifo_empty = 1'b0;
                3: rx_shift_idle = 1'b0;
                4: tx_shift_idle = 1'b0;
                default: irq_pending = 1'b1;
            endcase
            tick(3);
            check("R3", $sformatf("term %0d blocks entry", k), sleep_o, 1'b0);
        end
    endtask

    task automatic t_edge_mode();
        settle(1'b0, 8'h10);
        sleep_en = 1'b1;
        tick(1);
        check("R6", "edge mode sleeps with rx low", sleep_o, 1'b1);
        tick(4);
        check("R7", "stable rx keeps sleep", sleep_o, 1'b1);
        rx_pin = 1'b1;
        tick(3);
        check("R7", "rise wakes", wake_pulse_o, 1'b1);
        tick(1);
        check("R8", "no sleep right after wake", sleep_o, 1'b0);
        tick(1);
        check("R7", "re-entry with rx high", sleep_o, 1'b1);
        rx_pin = 1'b0;
        tick(2);
        check("R2", "edge: no early wake", wake_pulse_o, 1'b0);
        tick(1);
        check("R7", "fall wakes", wake_pulse_o, 1'b1);
    endtask

    task automatic t_enable_drop();
        settle(1'b1, 8'h00);
        sleep_en = 1'b1;
        tick(1);
        check("R9", "asleep before drop", sleep_o, 1'b1);
        sleep_en = 1'b0;
        tick(1);
        check("R9", "enable drop wakes", wake_pulse_o, 1'b1);
    endtask

    task automatic t_reserved_bits();
        settle(1'b0, 8'hEF);
        sleep_en = 1'b1;
        tick(3);
        check("R10", "other bits do not select edge", sleep_o, 1'b0);
        settle(1'b0, 8'h10);
        sleep_en = 1'b1;
        tick(1);
        check("R10", "bit 4 alone selects edge", sleep_o, 1'b1);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_level_entry_and_wake();
        t_idle_terms();
        t_edge_mode();
        t_enable_drop();
        t_reserved_bits();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule